// File: doc/BRIEF.md
# S-record stream loader

This block turns a stream of ASCII characters carrying S-records into byte-wide memory write commands. The characters typically come from a serial receiver, one per cycle in which `in_valid` is high, and there is no backpressure. The parser works one character at a time. It reads the record type digit and uses it to decide how many address bytes follow. It accumulates the checksum over the record's bytes, and it emits every data byte of a data record as a one-cycle write at a running byte address.

When a record closes, the parser compares the received checksum with the one it computed. A mismatch raises a one-cycle checksum error, and writes already issued stay issued. A well-formed termination record raises a one-cycle end-of-file pulse and latches the entry address it carries. Malformed input raises a one-cycle format error and puts the parser back into the state where it hunts for the next record start. Between records, line terminators and all other characters are skipped.

Top module: `srec_loader`

## Requirements
- R1: A character is consumed only in a cycle with `in_valid` high. While waiting for a record start, every character other than 'S' (0x53) is skipped without any output, including CR (0x0D) and LF (0x0A).
- R2: The character after 'S' must be an ASCII decimal digit other than '4'. A '4' or any non-digit raises `fmt_err` for one cycle, and the parser then waits for the next 'S'.
- R3: Hex digits are '0'-'9', 'A'-'F' and 'a'-'f'. Any other character in the count, address, data or checksum fields raises `fmt_err` for one cycle, and the rest of that record is skipped up to the next 'S'.
- R4: Types 0, 1, 5 and 9 carry a 2-byte address, types 2, 6 and 8 carry 3 bytes, and types 3 and 7 carry 4 bytes. The address is sent most significant byte first and is zero-extended to 32 bits.
- R5: Every data byte of a type 1, 2 or 3 record gives one `wr_en` pulse in the cycle after its second hex digit is consumed. In that cycle `wr_addr` equals the record address plus the byte's index and `wr_data` equals the byte.
- R6: Records of types 0, 5 and 6 are parsed fully but produce no write and no `eof`.
- R7: The checksum byte must equal the bitwise inverse of the low 8 bits of the sum of the count, address and data bytes. On a mismatch, `csum_err` pulses for one cycle in the cycle after the second checksum digit, and earlier writes of that record are not undone.
- R8: A type 7, 8 or 9 record with a correct checksum pulses `eof` for one cycle after its last checksum digit. `entry_addr` then shows the record's address and keeps it until the next `eof`.
- R9: A count byte smaller than the record's address byte count plus one raises `fmt_err` in the cycle after the count's second digit, and the record is skipped.
- R10: While `rst` is high and afterwards until input arrives, `wr_en`, `csum_err`, `fmt_err` and `eof` are low and `entry_addr` is zero.
- R11: At most one of `wr_en`, `csum_err`, `fmt_err` and `eof` is high in any cycle, and each is high only in the cycle right after a consumed character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A character is present on `in_char` this cycle |
| in_char | input | 8 | ASCII character |
| wr_en | output | 1 | One-cycle byte write strobe |
| wr_addr | output | 32 | Byte address of the write |
| wr_data | output | 8 | Byte to write |
| csum_err | output | 1 | One-cycle pulse: the record's checksum did not match |
| fmt_err | output | 1 | One-cycle pulse: malformed record |
| eof | output | 1 | One-cycle pulse: a termination record was accepted |
| entry_addr | output | 32 | Entry address from the last accepted termination record |

## Verification
The bench covers every address width. A design that sized the address from the wrong type would shift data bytes into the address, and the writes would land at the wrong place. Mixed-case hex, idle gaps in which an 'S' sits on the bus with `in_valid` low, and terminators between records all target the character filter. A filter that sampled without the valid, or that rejected lowercase, would raise a spurious format error. A short count byte, a '4' type digit, and a bad character placed after a write has already issued check that the parser drops the rest of the record without rewriting. A corrupted checksum on a record that has data checks that its writes still appear and that the error comes once, after the last digit.

// File: rtl/srec_pkg.sv
package srec_pkg;

    localparam int ADDR_W = 32;
    localparam int BYTE_W = 8;
    localparam int CHAR_W = 8;

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_TYPE,
        ST_COUNT,
        ST_ADDR,
        ST_DATA,
        ST_CSUM
    } parse_st_t;

    typedef struct packed {
        logic       is_hex;
        logic [3:0] nib;
        logic       is_start;
        logic       is_dig;
        logic [3:0] dig;
    } char_cls_t;

    function automatic logic [2:0] addr_len(input logic [3:0] rtype);
        case (rtype)
            4'd2, 4'd6, 4'd8: addr_len = 3'd3;
            4'd3, 4'd7:       addr_len = 3'd4;
            default:          addr_len = 3'd2;
        endcase
    endfunction

    function automatic logic carries_data(input logic [3:0] rtype);
        carries_data = (rtype == 4'd1) || (rtype == 4'd2) || (rtype == 4'd3);
    endfunction

    function automatic logic is_final(input logic [3:0] rtype);
        is_final = (rtype == 4'd7) || (rtype == 4'd8) || (rtype == 4'd9);
    endfunction

endpackage

// File: rtl/srec_char_class.sv
module srec_char_class
    import srec_pkg::*;
(
    input  logic [CHAR_W-1:0] ch,
    output char_cls_t         cls
);
    logic [CHAR_W-1:0] off_dig;
    logic [CHAR_W-1:0] off_up;
    logic [CHAR_W-1:0] off_lo;
    logic              dig_r, up_r, lo_r;

    always_comb begin
        off_dig = ch - CHAR_W'(8'h30);
        off_up  = ch - CHAR_W'(8'h37);
        off_lo  = ch - CHAR_W'(8'h57);
        dig_r   = (ch >= CHAR_W'(8'h30)) && (ch <= CHAR_W'(8'h39));
        up_r    = (ch >= CHAR_W'(8'h41)) && (ch <= CHAR_W'(8'h46));
        lo_r    = (ch >= CHAR_W'(8'h61)) && (ch <= CHAR_W'(8'h66));

        cls.is_dig   = dig_r;
        cls.dig      = off_dig[3:0];
        cls.is_hex   = dig_r || up_r || lo_r;
        cls.is_start = (ch == CHAR_W'(8'h53));
        if (up_r)      cls.nib = off_up[3:0];
        else if (lo_r) cls.nib = off_lo[3:0];
        else           cls.nib = off_dig[3:0];
    end
endmodule

// File: rtl/srec_csum.sv
module srec_csum
    import srec_pkg::*;
#(
    parameter int W = BYTE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         add,
    input  logic [W-1:0] din,
    output logic [W-1:0] sum
);
    always_ff @(posedge clk) begin
        if (rst || clr) sum <= '0;
        else if (add)   sum <= sum + din;
    end
endmodule

// File: rtl/srec_parse.sv
module srec_parse
    import srec_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int BW = BYTE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  char_cls_t     cls,
    input  logic [BW-1:0] sum,
    output logic          sum_clr,
    output logic          sum_add,
    output logic [BW-1:0] sum_din,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [BW-1:0] wr_data,
    output logic          csum_err,
    output logic          fmt_err,
    output logic          eof,
    output logic [AW-1:0] entry_addr
);
    parse_st_t     st;
    logic          phase;
    logic [3:0]    hi_nib;
    logic [3:0]    rtype;
    logic [BW-1:0] remain;
    logic [2:0]    alen_left;
    logic [AW-1:0] addr;
    logic [BW-1:0] byte_now;
    logic          in_field;
    logic          byte_done;
    logic [BW-1:0] min_cnt;

    always_comb begin
        byte_now  = BW'({hi_nib, cls.nib});
        in_field  = (st == ST_COUNT) || (st == ST_ADDR) ||
                    (st == ST_DATA)  || (st == ST_CSUM);
        byte_done = in_valid && in_field && cls.is_hex && phase;
        min_cnt   = BW'(addr_len(rtype)) + BW'(1);
        sum_clr   = in_valid && (st == ST_TYPE);
        sum_add   = byte_done && (st != ST_CSUM);
        sum_din   = byte_now;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_HUNT;
            phase      <= 1'b0;
            hi_nib     <= '0;
            rtype      <= '0;
            remain     <= '0;
            alen_left  <= '0;
            addr       <= '0;
            wr_en      <= 1'b0;
            wr_addr    <= '0;
            wr_data    <= '0;
            csum_err   <= 1'b0;
            fmt_err    <= 1'b0;
            eof        <= 1'b0;
            entry_addr <= '0;
        end else begin
            wr_en    <= 1'b0;
            csum_err <= 1'b0;
            fmt_err  <= 1'b0;
            eof      <= 1'b0;
            if (in_valid) begin
                case (st)
                    ST_HUNT: begin
                        if (cls.is_start) st <= ST_TYPE;
                    end
                    ST_TYPE: begin
                        if (cls.is_dig && cls.dig != 4'd4) begin
                            rtype <= cls.dig;
                            addr  <= '0;
                            phase <= 1'b0;
                            st    <= ST_COUNT;
                        end else begin
                            fmt_err <= 1'b1;
                            st      <= ST_HUNT;
                        end
                    end
                    default: begin
                        if (!cls.is_hex) begin
                            fmt_err <= 1'b1;
                            st      <= ST_HUNT;
                        end else if (!phase) begin
                            hi_nib <= cls.nib;
                            phase  <= 1'b1;
                        end else begin
                            phase <= 1'b0;
                            case (st)
                                ST_COUNT: begin
                                    remain    <= byte_now;
                                    alen_left <= addr_len(rtype);
                                    if (byte_now < min_cnt) begin
                                        fmt_err <= 1'b1;
                                        st      <= ST_HUNT;
                                    end else begin
                                        st <= ST_ADDR;
                                    end
                                end
                                ST_ADDR: begin
                                    addr      <= {addr[AW-BW-1:0], byte_now};
                                    remain    <= remain - BW'(1);
                                    alen_left <= alen_left - 3'd1;
                                    if (alen_left == 3'd1)
                                        st <= (remain == BW'(2)) ? ST_CSUM : ST_DATA;
                                end
                                ST_DATA: begin
                                    if (carries_data(rtype)) begin
                                        wr_en   <= 1'b1;
                                        wr_addr <= addr;
                                        wr_data <= byte_now;
                                        addr    <= addr + AW'(1);
                                    end
                                    remain <= remain - BW'(1);
                                    if (remain == BW'(2)) st <= ST_CSUM;
                                end
                                default: begin
                                    if (byte_now != ~sum) begin
                                        csum_err <= 1'b1;
                                    end else if (is_final(rtype)) begin
                                        eof        <= 1'b1;
                                        entry_addr <= addr;
                                    end
                                    st <= ST_HUNT;
                                end
                            endcase
                        end
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/srec_loader.sv
module srec_loader
    import srec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [CHAR_W-1:0] in_char,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic              csum_err,
    output logic              fmt_err,
    output logic              eof,
    output logic [ADDR_W-1:0] entry_addr
);
    char_cls_t         cls;
    logic              sum_clr, sum_add;
    logic [BYTE_W-1:0] sum_din, sum;

    srec_char_class u_cls (
        .ch  (in_char),
        .cls (cls)
    );

    srec_csum #(.W(BYTE_W)) u_csum (
        .clk (clk),
        .rst (rst),
        .clr (sum_clr),
        .add (sum_add),
        .din (sum_din),
        .sum (sum)
    );

    srec_parse #(.AW(ADDR_W), .BW(BYTE_W)) u_parse (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .cls        (cls),
        .sum        (sum),
        .sum_clr    (sum_clr),
        .sum_add    (sum_add),
        .sum_din    (sum_din),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .csum_err   (csum_err),
        .fmt_err    (fmt_err),
        .eof        (eof),
        .entry_addr (entry_addr)
    );
endmodule

// File: rtl/srec_loader_chk.sv
module srec_loader_chk
    import srec_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              wr_en,
    input logic              csum_err,
    input logic              fmt_err,
    input logic              eof,
    input logic [ADDR_W-1:0] entry_addr
);
    p_one_event_r11: assert property (@(posedge clk) disable iff (rst)
        $onehot0({wr_en, csum_err, fmt_err, eof}));

    p_needs_char_r1: assert property (@(posedge clk) disable iff (rst)
        (wr_en || csum_err || fmt_err || eof) |-> $past(in_valid));

    p_entry_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !$stable(entry_addr) |-> eof);

    p_write_pace_r5: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !wr_en);

    p_skip_after_fmt_r3: assert property (@(posedge clk) disable iff (rst)
        fmt_err |=> !wr_en);
endmodule

bind srec_loader srec_loader_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .wr_en      (wr_en),
    .csum_err   (csum_err),
    .fmt_err    (fmt_err),
    .eof        (eof),
    .entry_addr (entry_addr)
);

// File: tb/srec_loader_tb.sv
module srec_loader_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [7:0]  in_char = 8'h00;
    logic        wr_en, csum_err, fmt_err, eof;
    logic [31:0] wr_addr, entry_addr;
    logic [7:0]  wr_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        int          kind;
        logic [31:0] a;
        logic [7:0]  d;
        string       req;
    } exp_t;
    exp_t expq[$];

    always #5 clk = ~clk;

    srec_loader u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_char(in_char),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .csum_err(csum_err), .fmt_err(fmt_err), .eof(eof), .entry_addr(entry_addr)
    );

    function automatic string kname(input int k);
        case (k)
            0: kname = "write";
            1: kname = "csum_err";
            2: kname = "fmt_err";
            default: kname = "eof";
        endcase
    endfunction

    task automatic expect_ev(input int k, input logic [31:0] a, input logic [7:0] d, input string req);
        exp_t e;
        e.kind = k; e.a = a; e.d = d; e.req = req;
        expq.push_back(e);
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            int np;
            int k;
            np = int'(wr_en) + int'(csum_err) + int'(fmt_err) + int'(eof);
            if (np > 1) begin
                checks++; errors++;
                $display("FAIL R11 pulses=%0d expected<=1", np);
            end else if (np == 1) begin
                k = wr_en ? 0 : csum_err ? 1 : fmt_err ? 2 : 3;
                checks++;
                if (expq.size() == 0) begin
                    errors++;
                    $display("FAIL R11 unexpected %s expected none", kname(k));
                end else begin
                    exp_t e;
                    e = expq.pop_front();
                    if (k != e.kind) begin
                        errors++;
                        $display("FAIL %s got %s expected %s", e.req, kname(k), kname(e.kind));
                    end else if (k == 0 && (wr_addr != e.a || wr_data != e.d)) begin
                        errors++;
                        $display("FAIL %s write %h/%h expected %h/%h", e.req, wr_addr, wr_data, e.a, e.d);
                    end else if (k == 3 && entry_addr != e.a) begin
                        errors++;
                        $display("FAIL %s entry %h expected %h", e.req, entry_addr, e.a);
                    end
                end
            end
        end
    end

    function automatic logic [7:0] hexc(input logic [3:0] n, input bit lower);
        if (n < 4'd10) hexc = 8'h30 + 8'(n);
        else           hexc = (lower ? 8'h57 : 8'h37) + 8'(n);
    endfunction

    task automatic put_char(input logic [7:0] c);
        in_char  = c;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic gap(input int n);
        in_char = 8'h53;
        repeat (n) @(negedge clk);
    endtask

    task automatic put_byte(input logic [7:0] b, input bit lower);
        put_char(hexc(b[7:4], lower));
        put_char(hexc(b[3:0], lower));
    endtask

    task automatic put_str(input string s);
        for (int i = 0; i < s.len(); i++) put_char(s[i]);
    endtask

    task automatic send_record(input int t, input logic [31:0] a, input logic [7:0] dat[$],
                               input bit bad, input bit lower, input bit gaps, input string req);
        int ab;
        logic [7:0] cnt, sum, cs;
        ab  = (t == 2 || t == 6 || t == 8) ? 3 : (t == 3 || t == 7) ? 4 : 2;
        cnt = 8'(ab + dat.size() + 1);
        sum = cnt;
        for (int i = 0; i < ab; i++) sum += a[8*(ab-1-i) +: 8];
        foreach (dat[i]) sum += dat[i];
        cs = bad ? (~sum ^ 8'h01) : ~sum;
        if (t >= 1 && t <= 3)
            foreach (dat[i]) expect_ev(0, a + 32'(i), dat[i], req);
        if (bad) expect_ev(1, 0, 0, "R7");
        else if (t >= 7) expect_ev(3, a, 0, "R8");
        put_char(8'h53);
        put_char(8'h30 + 8'(t));
        put_byte(cnt, lower);
        for (int i = 0; i < ab; i++) begin
            put_byte(a[8*(ab-1-i) +: 8], lower);
            if (gaps) gap(2);
        end
        foreach (dat[i]) begin
            put_byte(dat[i], lower);
            if (gaps) gap(1);
        end
        put_byte(cs, lower);
        put_char(8'h0D);
        put_char(8'h0A);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] d[$];
        repeat (3) @(negedge clk);
        checks++;
        if (wr_en || csum_err || fmt_err || eof || entry_addr != 0) begin
            errors++;
            $display("FAIL R10 outputs %b%b%b%b/%h expected 0000/0", wr_en, csum_err, fmt_err, eof, entry_addr);
        end
        rst = 1'b0;
        @(negedge clk);

        // R1: noise and terminators between records, an S with valid low
        put_str("\r\n \nxyz");
        gap(3);

        // R4 R5: 16-bit data record with idle gaps
        d = '{8'h11, 8'h22, 8'hA5, 8'h5A};
        send_record(1, 32'h0000_1230, d, 0, 0, 1, "R5");
        // R3 R4: 24-bit, lowercase hex
        d = '{8'hDE, 8'hAD, 8'hBE};
        send_record(2, 32'h000A_BCFE, d, 0, 1, 0, "R4");
        // R4: 32-bit
        d = '{8'h9D, 8'hE3, 8'hBF};
        send_record(3, 32'h4000_0000, d, 0, 0, 0, "R4");
        // R6: header and count records write nothing
        d = '{8'h68, 8'h64, 8'h72};
        send_record(0, 32'h0000_0000, d, 0, 0, 0, "R6");
        d = '{};
        send_record(5, 32'h0000_0003, d, 0, 0, 0, "R6");
        d = '{8'h01};
        send_record(6, 32'h0000_0007, d, 0, 0, 0, "R6");
        // R7: bad checksum after writes
        d = '{8'h77, 8'h88};
        send_record(1, 32'h0000_2000, d, 1, 0, 0, "R7");
        // R8: termination records
        d = '{};
        send_record(7, 32'h4000_0000, d, 0, 0, 0, "R8");
        send_record(8, 32'h0012_3456, d, 0, 1, 0, "R8");
        send_record(9, 32'h0000_BEEF, d, 0, 0, 0, "R8");
        // R7: bad checksum on termination gives no eof
        send_record(7, 32'h1111_2222, d, 1, 0, 0, "R7");

        // R2: reserved type and non-digit type
        expect_ev(2, 0, 0, "R2");
        put_str("S4030000FC\r\n");
        expect_ev(2, 0, 0, "R2");
        put_str("SX\r\n");
        // R3: bad char in count
        expect_ev(2, 0, 0, "R3");
        put_str("S1G3\r\n");
        // R3: bad char after a write already issued
        expect_ev(0, 32'h0000_1000, 8'hAA, "R3");
        expect_ev(2, 0, 0, "R3");
        put_str("S1051000AAZ77\r\n");
        // R9: count too small
        expect_ev(2, 0, 0, "R9");
        put_str("S1020000FD\r\n");

        // parser recovered: good record after errors
        d = '{8'h42};
        send_record(3, 32'h8000_00FF, d, 0, 0, 0, "R2");

        repeat (4) @(negedge clk);
        checks++;
        if (entry_addr != 32'h0000_BEEF) begin
            errors++;
            $display("FAIL R8 held entry %h expected 0000beef", entry_addr);
        end
        checks++;
        if (expq.size() != 0) begin
            errors++;
            $display("FAIL R5 missing events %0d expected 0", expq.size());
        end
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule